// File: doc/BRIEF.md
# Sleep and Wake Controller

This block is the power-management sequencer of a small processor core. Software first sets a sleep-enable bit and picks one of five low-power modes through a 3-bit code. It then issues the sleep instruction, which reaches this block as a one-cycle strobe. If the enable bit is set when the strobe arrives, the controller stalls the core and drops the clock enables of the domains that the chosen mode turns off. The mode code is captured at that moment, so later writes to the mode field have no effect until the next entry.

While the core is asleep, each mode admits its own set of wake sources. The two external pin interrupts wake the deeper modes only when they are configured as level-sensitive. The timer interrupt wakes the core only when the timer runs from its own asynchronous clock. Power-down and power-save stop the oscillator, so a wake in those modes first waits for a start-up-done indication. Every wake then holds the core stalled for a fixed extra window with all clocks running. On the last cycle of that window the controller pulses a completion strobe and reports the resume target: the instruction after the sleep instruction, or the reset vector if a reset request arrived during sleep. An interrupt wake never signals a restart, so the register file and memories keep their contents.

Top module: `slp_wake_ctrl`

## Requirements
- R1: When the core is running and `sleep_strobe` and `sleep_en` are both 1 at a clock edge, `core_stall` is 1 from the next cycle and the clock enables follow the mode captured at that edge.
- R2: A `sleep_strobe` with `sleep_en` at 0 has no effect: `core_stall` stays 0 and all clock enables stay 1.
- R3: Clock enables while asleep, listed as {cpu,flash,io,adc,tmr,osc}: code 000 gives 001111, code 001 gives 000111, code 010 gives 000000, code 011 gives 000010 and code 110 gives 000001.
- R4: Codes 100, 101 and 111 behave as code 000. The code is captured at entry, and changes to `mode_sel` while asleep do not change the gating.
- R5: A wake source counts only if its `irq_req` and `irq_en` bits are both 1 and the active mode admits it. Line 0 and line 1 are the external pins, line 2 is the timer and line 3 is the ADC. Code 000 admits every line. Code 001 admits line 3, line 2 if `tmr_async` is 1, and line 0 or 1 if its `ext_level` bit is 1. Codes 010 and 110 admit line 0 or 1 only if its `ext_level` bit is 1. Code 011 admits the same lines plus line 2 if `tmr_async` is 1. Any request that does not count leaves the core asleep with its gating unchanged.
- R6: In codes 010 and 011, a wake enables only the oscillator clock and keeps the core stalled until `startup_done` is 1 at a clock edge.
- R7: After a wake (or after start-up in R6), `core_stall` stays 1 for exactly 4 cycles with all clock enables at 1. `wake_done` pulses on the 4th of these cycles, and `core_stall` is 0 on the next cycle.
- R8: A `rst_req` while asleep or in start-up wakes the core in any mode, and `wake_by_reset` is 1 during `wake_done`. A wake caused only by an interrupt gives `wake_by_reset` 0.
- R9: After `rst_n` is released, the core is running: `core_stall` and `wake_done` are 0 and all clock enables are 1.
- R10: While the core is running, `rst_req` and interrupt requests have no effect on `core_stall`, `wake_done` or the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset of the controller |
| sleep_en | input | 1 | Sleep-enable control bit |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| mode_sel | input | 3 | Sleep mode code |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Interrupt enables |
| ext_level | input | 2 | 1 = external pin 0/1 is level-sensitive |
| tmr_async | input | 1 | Timer runs from its asynchronous clock |
| rst_req | input | 1 | Reset request (wakes from sleep to the reset vector) |
| startup_done | input | 1 | Oscillator start-up time has elapsed |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | Peripheral I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_tmr | output | 1 | Asynchronous timer clock enable |
| clk_en_osc | output | 1 | Main oscillator enable |
| core_stall | output | 1 | Holds the core pipeline |
| wake_done | output | 1 | One-cycle pulse on the last stalled cycle of a wake |
| wake_by_reset | output | 1 | Valid with wake_done: 1 = restart at reset vector |

## Verification
A wrongly captured or decoded mode shows on the clock-enable pins on the first cycle after entry. It also shows when a wake request that should be ignored ends the sleep, or one that should count fails to. A sequencer stuck or skipping a state shows as a stall window that is not exactly four cycles after the wake or after start-up. It can also show as the oscillator-only pattern missing during start-up, which is visible within one cycle. A lost reset cause shows as a wrong `wake_by_reset` value together with the `wake_done` pulse.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_STARTUP, ST_HOLD} slp_state_e;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'b000,
    MD_ADCNR = 3'b001,
    MD_PDOWN = 3'b010,
    MD_PSAVE = 3'b011,
    MD_STBY  = 3'b110
  } slp_mode_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic tmr;
    logic osc;
  } clk_en_t;

  localparam clk_en_t CLK_ALL_ON = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam clk_en_t CLK_OSC_ONLY = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  // reserved codes fold onto the lightest mode
  function automatic slp_mode_e norm_mode(input logic [2:0] code);
    case (code)
      3'b001:  return MD_ADCNR;
      3'b010:  return MD_PDOWN;
      3'b011:  return MD_PSAVE;
      3'b110:  return MD_STBY;
      default: return MD_IDLE;
    endcase
  endfunction

  function automatic clk_en_t mode_clocks(input slp_mode_e m);
    case (m)
      MD_ADCNR: return '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
      MD_PDOWN: return '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      MD_PSAVE: return '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      MD_STBY:  return '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      default:  return '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    endcase
  endfunction

  function automatic logic stops_osc(input slp_mode_e m);
    return (m == MD_PDOWN) || (m == MD_PSAVE);
  endfunction

endpackage

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
#(
  parameter int NIRQ     = 8,
  parameter int EXT0_IDX = 0,
  parameter int EXT1_IDX = 1,
  parameter int TMR_IDX  = 2,
  parameter int ADC_IDX  = 3
) (
  input  slp_mode_e         mode,
  input  logic [NIRQ-1:0]   req,
  input  logic [NIRQ-1:0]   en,
  input  logic [1:0]        ext_level,
  input  logic              tmr_async,
  output logic              wake_irq
);

  logic [NIRQ-1:0] admit;
  logic            is_idle;

  assign is_idle = (mode == MD_IDLE);

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    if (i == EXT0_IDX || i == EXT1_IDX) begin : g_ext
      localparam int SEL = (i == EXT1_IDX) ? 1 : 0;
      assign admit[i] = is_idle || ext_level[SEL];
    end else if (i == TMR_IDX) begin : g_tmr
      assign admit[i] = is_idle ||
                        (tmr_async && (mode == MD_ADCNR || mode == MD_PSAVE));
    end else if (i == ADC_IDX) begin : g_adc
      assign admit[i] = is_idle || (mode == MD_ADCNR);
    end else begin : g_io
      assign admit[i] = is_idle;
    end
  end

  assign wake_irq = |(req & en & admit);

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter,
  input  logic       wake_irq,
  input  logic       rst_req,
  input  logic       deep,
  input  logic       startup_done,
  output slp_state_e state,
  output logic       wake_done,
  output logic       by_reset
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] hold_cnt;
  logic          rst_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      hold_cnt  <= '0;
      rst_cause <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (enter) begin
            state     <= ST_SLEEP;
            rst_cause <= 1'b0;
          end
        end
        ST_SLEEP: begin
          if (rst_req || wake_irq) begin
            rst_cause <= rst_req;
            hold_cnt  <= '0;
            state     <= deep ? ST_STARTUP : ST_HOLD;
          end
        end
        ST_STARTUP: begin
          if (rst_req) rst_cause <= 1'b1;
          if (startup_done) begin
            hold_cnt <= '0;
            state    <= ST_HOLD;
          end
        end
        default: begin
          if (hold_cnt == LAST) state <= ST_RUN;
          else                  hold_cnt <= hold_cnt + 1'b1;
        end
      endcase
    end
  end

  assign wake_done = (state == ST_HOLD) && (hold_cnt == LAST);
  assign by_reset  = rst_cause;

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_pkg::*;
#(
  parameter int NIRQ     = 8,
  parameter int HOLD_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_en,
  input  logic            sleep_strobe,
  input  logic [2:0]      mode_sel,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [1:0]      ext_level,
  input  logic            tmr_async,
  input  logic            rst_req,
  input  logic            startup_done,
  output logic            clk_en_cpu,
  output logic            clk_en_flash,
  output logic            clk_en_io,
  output logic            clk_en_adc,
  output logic            clk_en_tmr,
  output logic            clk_en_osc,
  output logic            core_stall,
  output logic            wake_done,
  output logic            wake_by_reset
);

  slp_state_e state;
  slp_mode_e  mode_q;
  clk_en_t    gate;
  logic       enter;
  logic       wake_irq;

  assign enter = sleep_strobe && sleep_en && (state == ST_RUN);

  // R4: mode captured only on the entry edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MD_IDLE;
    else if (enter) mode_q <= norm_mode(mode_sel);
  end

  slp_wake_filter #(.NIRQ(NIRQ)) u_filter (
    .mode      (mode_q),
    .req       (irq_req),
    .en        (irq_en),
    .ext_level (ext_level),
    .tmr_async (tmr_async),
    .wake_irq  (wake_irq)
  );

  slp_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter        (enter),
    .wake_irq     (wake_irq),
    .rst_req      (rst_req),
    .deep         (stops_osc(mode_q)),
    .startup_done (startup_done),
    .state        (state),
    .wake_done    (wake_done),
    .by_reset     (wake_by_reset)
  );

  always_comb begin
    case (state)
      ST_SLEEP:   gate = mode_clocks(mode_q);
      ST_STARTUP: gate = CLK_OSC_ONLY;
      default:    gate = CLK_ALL_ON;
    endcase
  end

  assign clk_en_cpu   = gate.cpu;
  assign clk_en_flash = gate.flash;
  assign clk_en_io    = gate.io;
  assign clk_en_adc   = gate.adc;
  assign clk_en_tmr   = gate.tmr;
  assign clk_en_osc   = gate.osc;
  assign core_stall   = (state != ST_RUN);

endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk
  import slp_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sleep_en,
  input logic      sleep_strobe,
  input slp_mode_e mode_q,
  input logic      clk_en_cpu,
  input logic      clk_en_flash,
  input logic      clk_en_io,
  input logic      clk_en_adc,
  input logic      clk_en_tmr,
  input logic      clk_en_osc,
  input logic      core_stall,
  input logic      wake_done
);

  // R1
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stall && sleep_strobe && sleep_en) |=> (core_stall && !clk_en_cpu && !clk_en_flash));

  // R2
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stall && sleep_strobe && !sleep_en) |=> !core_stall);

  // R9
  run_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_stall |-> (clk_en_cpu && clk_en_flash && clk_en_io && clk_en_adc && clk_en_tmr && clk_en_osc));

  // R3
  idle_domains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && !clk_en_cpu && mode_q == MD_IDLE) |-> (clk_en_io && clk_en_adc && clk_en_tmr && clk_en_osc));

  // R7
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_stall) |-> $past(wake_done));

  // R7
  done_ends_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !core_stall);

  // R7
  done_all_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (core_stall && clk_en_cpu && clk_en_flash && clk_en_io && clk_en_osc));

endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_en     (sleep_en),
  .sleep_strobe (sleep_strobe),
  .mode_q       (mode_q),
  .clk_en_cpu   (clk_en_cpu),
  .clk_en_flash (clk_en_flash),
  .clk_en_io    (clk_en_io),
  .clk_en_adc   (clk_en_adc),
  .clk_en_tmr   (clk_en_tmr),
  .clk_en_osc   (clk_en_osc),
  .core_stall   (core_stall),
  .wake_done    (wake_done)
);

// File: tb/slp_wake_ctrl_bench.sv
module slp_wake_ctrl_bench;

  localparam int NIRQ = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sleep_en = 1'b0;
  logic            sleep_strobe = 1'b0;
  logic [2:0]      mode_sel = 3'b000;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic [1:0]      ext_level = 2'b00;
  logic            tmr_async = 1'b0;
  logic            rst_req = 1'b0;
  logic            startup_done = 1'b0;
  logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_tmr, clk_en_osc;
  logic core_stall, wake_done, wake_by_reset;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  slp_wake_ctrl #(.NIRQ(NIRQ), .HOLD_CYC(4)) u_slp_wake_ctrl (.*);

  wire [5:0] clks = {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_tmr, clk_en_osc};

  function automatic logic [5:0] exp_clk(input logic [2:0] code);
    case (code)
      3'b001:  return 6'b000111;
      3'b010:  return 6'b000000;
      3'b011:  return 6'b000010;
      3'b110:  return 6'b000001;
      default: return 6'b001111;
    endcase
  endfunction

  function automatic bit exp_deep(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic bit exp_admit(input logic [2:0] code, input int idx,
                                   input logic [1:0] lvl, input logic asy);
    bit idle = !(code == 3'b001 || code == 3'b010 || code == 3'b011 || code == 3'b110);
    if (idle) return 1'b1;
    if (idx == 0 || idx == 1) return lvl[idx];
    if (idx == 2) return asy && (code == 3'b001 || code == 3'b011);
    if (idx == 3) return code == 3'b001;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(!core_stall && !wake_done && clks == 6'b111111, "R9 reset", {core_stall, clks}, 6'b111111);
    @(negedge clk) rst_n = 1'b1;
    step();
    chk(!core_stall && clks == 6'b111111, "R9 after release", {core_stall, clks}, 6'b111111);

    // R2: strobe without enable
    @(negedge clk) begin sleep_strobe = 1'b1; sleep_en = 1'b0; mode_sel = 3'b010; end
    step();
    chk(!core_stall && clks == 6'b111111, "R2 strobe ignored", {core_stall, clks}, 6'b111111);
    @(negedge clk) sleep_strobe = 1'b0;

    // R10: reset request and interrupts while running
    @(negedge clk) begin rst_req = 1'b1; irq_req = '1; irq_en = '1; end
    step();
    chk(!core_stall && !wake_done && clks == 6'b111111, "R10 running", {core_stall, wake_done, clks}, 6'b111111);
    @(negedge clk) begin rst_req = 1'b0; irq_req = '0; irq_en = '0; end

    for (int t = 0; t < 48; t++) begin
      logic [2:0] code;
      logic [1:0] lvl;
      logic       asy;
      bit         woke;
      bit         exp_rst;
      int         hc;
      bit         seen;
      code = (t < 8) ? 3'(t) : 3'($urandom % 8);
      lvl  = 2'($urandom % 4);
      asy  = 1'($urandom % 2);
      exp_rst = 1'b0;
      @(negedge clk) begin
        mode_sel = code; sleep_en = 1'b1; sleep_strobe = 1'b1;
        ext_level = lvl; tmr_async = asy;
      end
      step();
      // R1, R3, R4
      chk(core_stall && clks == exp_clk(code), "R1/R3 entry gating", {core_stall, clks}, {1'b1, exp_clk(code)});
      @(negedge clk) begin sleep_strobe = 1'b0; sleep_en = 1'b0; mode_sel = 3'($urandom); end

      woke = 1'b0;
      for (int k = 0; k < 8 && !woke; k++) begin
        bit expw;
        @(negedge clk) begin
          irq_req = NIRQ'($urandom & $urandom);
          irq_en  = NIRQ'($urandom);
          rst_req = (k == 7) || (($urandom % 16) == 0);
        end
        expw = rst_req;
        for (int i = 0; i < NIRQ; i++)
          if (irq_req[i] && irq_en[i] && exp_admit(code, i, lvl, asy)) expw = 1'b1;
        if (expw) exp_rst = rst_req;
        step();
        if (expw) begin
          woke = 1'b1;
          // R5, R6, R8
          if (exp_deep(code))
            chk(core_stall && clks == 6'b000001, "R6 start-up gating", {core_stall, clks}, 7'b1000001);
          else
            chk(core_stall && clks == 6'b111111, "R5 wake to hold", {core_stall, clks}, 7'b1111111);
        end else begin
          // R4, R5: ignored requests and mode writes
          chk(core_stall && clks == exp_clk(code), "R5/R4 still asleep", {core_stall, clks}, {1'b1, exp_clk(code)});
        end
      end
      @(negedge clk) begin irq_req = '0; irq_en = '0; rst_req = 1'b0; end

      if (exp_deep(code)) begin
        repeat (2) begin
          step();
          chk(core_stall && clks == 6'b000001, "R6 waits for start-up", {core_stall, clks}, 7'b1000001);
        end
        @(negedge clk) startup_done = 1'b1;
        step();
        @(negedge clk) startup_done = 1'b0;
      end

      hc = 0;
      seen = 1'b0;
      while (core_stall && hc < 20) begin
        hc++;
        chk(clks == 6'b111111, "R7 hold clocks", clks, 6'b111111);
        if (wake_done) begin
          seen = 1'b1;
          chk(hc == 4, "R7 done on 4th cycle", hc, 4);
          chk(wake_by_reset == exp_rst, "R8 resume target", wake_by_reset, exp_rst);
        end
        step();
      end
      chk(seen && hc == 4, "R7 hold length", hc, 4);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule